// File: doc/BRIEF.md
# Prioritized Interrupt Flag Controller

This block collects eight interrupt sources of a bus peripheral: three transmit-buffer-empty events, two receive-buffer-full events, an error event, a bus-activity wake event and a message-error event. Each source owns one flag bit and one enable bit, and both sit at the same bit position. Hardware event pulses set the flags. A host reaches the flag, enable and overflow registers through a simple register port. A host write carries a per-bit mask, so a plain write and a masked bit-modify use the same port.

The block drives an active-low interrupt line and a 3-bit code. The code names the most urgent source that is both pending and enabled. The block also watches receive-frame acceptance: a frame accepted for a buffer that is still full sets a sticky overflow bit and raises the error flag. While the peripheral sleeps, bus activity with the wake enable set produces a one-cycle wake request, which the mode logic uses to leave sleep for listen-only operation.

Top module: `ifc_ctrl`

## Requirements
- R1: After reset all flags, enables and overflow bits read 0, `int_n_o` is 1 and `icod_o` is 000.
- R2: Register select codes are 0 = flags, 1 = enables, 2 = overflow (bits 1:0). Flag and enable bit positions are 0 RX0, 1 RX1, 2 TX0, 3 TX1, 4 TX2, 5 error, 6 wake, 7 message error. `rd_data_o` shows the selected register combinationally.
- R3: `int_n_o` is 0 exactly when some flag and its enable are both 1. It changes in the cycle after the flag or enable register changes.
- R4: A host write of 0 to a flag leaves that flag at 1 while its `hold_i` bit is 1.
- R5: A host write of 1 to a flag whose enable is 1 drives `int_n_o` low, the same as a hardware event does.
- R6: A host write changes only the bits whose mask bit is 1. A hardware set of an unmasked flag in the same cycle is kept. A hardware set and a host clear of the same flag in one cycle leave the flag at 1.
- R7: `icod_o` considers only enabled pending sources. Its codes are error 001, wake 010, TX0 011, TX1 100, TX2 101, RX0 110, RX1 111, and the lowest nonzero code wins. With nothing pending it is 000.
- R8: Clearing the winning source moves `icod_o` to the next pending enabled source on the next cycle.
- R9: The message-error source has no code: with only that flag pending and enabled, `int_n_o` is 0 and `icod_o` is 000.
- R10: An `rx_accept_i` pulse for a buffer whose RX flag is 0 sets that flag. If the flag is already 1, the pulse sets that buffer's overflow bit and the error flag instead.
- R11: Overflow bits stay set until a host write to select 2 clears them. A write to the flag register does not clear them.
- R12: With `sleep_i` = 1, `bus_act_i` = 1 and the wake enable set, the wake flag is set and `wake_req_o` is 1 for the following cycle. Without the enable, or without `sleep_i`, neither happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hw_set_i | input | 8 | Per-source hardware event pulses |
| hold_i | input | 8 | Per-source condition still active; blocks host clear |
| rx_accept_i | input | 2 | Frame accepted for receive buffer 0/1 |
| sleep_i | input | 1 | Peripheral is in sleep |
| bus_act_i | input | 1 | Activity seen on the bus |
| wr_en_i | input | 1 | Host write strobe |
| wr_sel_i | input | 2 | Host register select |
| wr_mask_i | input | 8 | Bits to change (all ones for a plain write) |
| wr_data_i | input | 8 | Write data |
| rd_sel_i | input | 2 | Read register select |
| rd_data_o | output | 8 | Read data |
| int_n_o | output | 1 | Active-low interrupt |
| icod_o | output | 3 | Highest-priority pending enabled source code |
| wake_req_o | output | 1 | One-cycle wake request |

## Verification
The priority encoder is tried with a table of flag and enable pairs. Single pending sources check each code value. Nested sets check that the lower code wins. Disabled high-priority sources check that masking moves the winner, and the message-error-only pattern separates the interrupt line from the code. Directed sequences then clear winners one by one to show that the code steps down. They also race hardware sets against masked clears, hold a condition during a clear, fill a receive buffer twice to raise an overflow, and apply bus activity with and without sleep and enable.

// File: rtl/ifc_pkg.sv
package ifc_pkg;
   localparam int SRC_W  = 8;
   localparam int NUM_RX = 2;

   localparam int B_RX0  = 0;
   localparam int B_RX1  = 1;
   localparam int B_TX0  = 2;
   localparam int B_TX1  = 3;
   localparam int B_TX2  = 4;
   localparam int B_ERR  = 5;
   localparam int B_WAK  = 6;
   localparam int B_MERR = 7;

   localparam logic [1:0] SEL_FLAG = 2'd0;
   localparam logic [1:0] SEL_EN   = 2'd1;
   localparam logic [1:0] SEL_OVF  = 2'd2;

   // source bit position that owns a given priority code (code 0 = none)
   function automatic int src_of_code(input int code);
      case (code)
         1:       return B_ERR;
         2:       return B_WAK;
         3:       return B_TX0;
         4:       return B_TX1;
         5:       return B_TX2;
         6:       return B_RX0;
         7:       return B_RX1;
         default: return B_MERR;
      endcase
   endfunction
endpackage

// File: rtl/ifc_bit_bank.sv
module ifc_bit_bank #(
   parameter int W        = 8,
   parameter bit HAS_HOLD = 1'b0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         wr_i,
   input  logic [W-1:0] mask_i,
   input  logic [W-1:0] data_i,
   input  logic [W-1:0] set_i,
   input  logic [W-1:0] hold_i,
   output logic [W-1:0] q_o
);
   logic [W-1:0] hold_eff;
   logic [W-1:0] q;

   if (W < 1) begin : g_bad_w
      $error("ifc_bit_bank: W must be at least 1");
   end

   assign hold_eff = hold_i & {W{HAS_HOLD}};

   for (genvar i = 0; i < W; i++) begin : g_bit
      logic host_bit;
      logic nxt;
      assign host_bit = wr_i & mask_i[i];
      // a held condition keeps a set bit alive; a hardware set always wins
      assign nxt = (host_bit ? (data_i[i] | (q[i] & hold_eff[i])) : q[i]) | set_i[i];

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q[i] <= 1'b0;
         else        q[i] <= nxt;
      end

      a_r6_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
         set_i[i] |=> q[i]);
      a_r6_unmasked_stable: assert property (@(posedge clk) disable iff (!rst_n)
         (!(wr_i && mask_i[i]) && !set_i[i]) |=> $stable(q[i]));
      if (HAS_HOLD) begin : g_hold_chk
         a_r4_hold_keeps: assert property (@(posedge clk) disable iff (!rst_n)
            (hold_i[i] && q[i]) |=> q[i]);
      end
   end

   assign q_o = q;
endmodule

// File: rtl/ifc_prio_enc.sv
module ifc_prio_enc
   import ifc_pkg::*;
#(
   parameter int W      = SRC_W,
   parameter int CODE_W = 3
) (
   input  logic [W-1:0]      pend_i,
   output logic [CODE_W-1:0] code_o
);
   localparam int NCODE = (1 << CODE_W);

   if (W != SRC_W || CODE_W != 3) begin : g_bad_cfg
      $error("ifc_prio_enc: code map is fixed to 8 sources and 3-bit code");
   end

   always_comb begin
      code_o = '0;
      // walk from least to most urgent so the lowest code is written last
      for (int c = NCODE - 1; c >= 1; c--) begin
         if (pend_i[src_of_code(c)]) code_o = CODE_W'(c);
      end
   end

   always_comb begin
      if (code_o != '0) a_r7_code_pending: assert (pend_i[src_of_code(int'(code_o))]);
      if (pend_i[B_ERR]) a_r7_err_first: assert (code_o == CODE_W'(1));
   end
endmodule

// File: rtl/ifc_ctrl.sv
module ifc_ctrl
   import ifc_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [7:0]       hw_set_i,
   input  logic [7:0]       hold_i,
   input  logic [1:0]       rx_accept_i,
   input  logic             sleep_i,
   input  logic             bus_act_i,
   input  logic             wr_en_i,
   input  logic [1:0]       wr_sel_i,
   input  logic [7:0]       wr_mask_i,
   input  logic [7:0]       wr_data_i,
   input  logic [1:0]       rd_sel_i,
   output logic [7:0]       rd_data_o,
   output logic             int_n_o,
   output logic [2:0]       icod_o,
   output logic             wake_req_o
);
   localparam int RX_PAD = SRC_W - NUM_RX;

   logic [SRC_W-1:0]  flag_q, en_q, flag_set, pend;
   logic [NUM_RX-1:0] ovf_q, rx_full, ovf_evt, rx_fill;
   logic              wake_evt, wake_q;
   logic              wr_flag, wr_en_reg, wr_ovf;

   if (NUM_RX != 2 || SRC_W != 8) begin : g_bad_cfg
      $error("ifc_ctrl: layout requires 8 sources and 2 receive buffers");
   end

   assign wr_flag   = wr_en_i && (wr_sel_i == SEL_FLAG);
   assign wr_en_reg = wr_en_i && (wr_sel_i == SEL_EN);
   assign wr_ovf    = wr_en_i && (wr_sel_i == SEL_OVF);

   assign rx_full  = {flag_q[B_RX1], flag_q[B_RX0]};
   assign ovf_evt  = rx_accept_i & rx_full;
   assign rx_fill  = rx_accept_i & ~rx_full;
   assign wake_evt = sleep_i & bus_act_i & en_q[B_WAK];

   always_comb begin
      flag_set         = hw_set_i;
      flag_set[B_RX0]  = hw_set_i[B_RX0] | rx_fill[0];
      flag_set[B_RX1]  = hw_set_i[B_RX1] | rx_fill[1];
      flag_set[B_ERR]  = hw_set_i[B_ERR] | (|ovf_evt);
      flag_set[B_WAK]  = hw_set_i[B_WAK] | wake_evt;
   end

   ifc_bit_bank #(.W(SRC_W), .HAS_HOLD(1'b1)) u_flags (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_flag), .mask_i(wr_mask_i),
      .data_i(wr_data_i), .set_i(flag_set), .hold_i(hold_i), .q_o(flag_q));

   ifc_bit_bank #(.W(SRC_W), .HAS_HOLD(1'b0)) u_enables (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_en_reg), .mask_i(wr_mask_i),
      .data_i(wr_data_i), .set_i('0), .hold_i('0), .q_o(en_q));

   ifc_bit_bank #(.W(NUM_RX), .HAS_HOLD(1'b0)) u_ovf (
      .clk(clk), .rst_n(rst_n), .wr_i(wr_ovf), .mask_i(wr_mask_i[NUM_RX-1:0]),
      .data_i(wr_data_i[NUM_RX-1:0]), .set_i(ovf_evt), .hold_i('0), .q_o(ovf_q));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) wake_q <= 1'b0;
      else        wake_q <= wake_evt;
   end

   assign pend = flag_q & en_q;

   ifc_prio_enc #(.W(SRC_W), .CODE_W(3)) u_enc (.pend_i(pend), .code_o(icod_o));

   assign int_n_o    = ~(|pend);
   assign wake_req_o = wake_q;

   always_comb begin
      case (rd_sel_i)
         SEL_FLAG: rd_data_o = flag_q;
         SEL_EN:   rd_data_o = en_q;
         SEL_OVF:  rd_data_o = {{RX_PAD{1'b0}}, ovf_q};
         default:  rd_data_o = '0;
      endcase
   end

   a_r3_set_lowers_int: assert property (@(posedge clk) disable iff (!rst_n)
      (|(hw_set_i & en_q) && !wr_en_reg) |=> !int_n_o);
   a_r7_code_implies_int: assert property (@(posedge clk) disable iff (!rst_n)
      (icod_o != 3'd0) |-> !int_n_o);
   a_r11_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (|ovf_q && !wr_ovf) |=> ((ovf_q & $past(ovf_q)) == $past(ovf_q)));
   a_r10_ovf_raises_err: assert property (@(posedge clk) disable iff (!rst_n)
      (|ovf_evt) |=> flag_q[B_ERR]);
   a_r12_wake_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (sleep_i && bus_act_i && en_q[B_WAK]) |=> (wake_req_o && flag_q[B_WAK]));
   a_r12_no_wake_awake: assert property (@(posedge clk) disable iff (!rst_n)
      !sleep_i |=> !wake_req_o);
endmodule

// File: tb/ifc_ctrl_tb.sv
`timescale 1ns/1ps
module ifc_ctrl_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] hw_set_i = '0, hold_i = '0, wr_mask_i = '0, wr_data_i = '0;
   logic [1:0] rx_accept_i = '0, wr_sel_i = '0, rd_sel_i = '0;
   logic       sleep_i = 1'b0, bus_act_i = 1'b0, wr_en_i = 1'b0;
   logic [7:0] rd_data_o;
   logic       int_n_o, wake_req_o;
   logic [2:0] icod_o;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   ifc_ctrl u_dut (.*);

   // {enables, flags, expected code, expected int_n}
   localparam logic [19:0] VEC [13] = '{
      {8'hFF, 8'h00, 3'd0, 1'b1},
      {8'hFF, 8'h01, 3'd6, 1'b0},
      {8'hFF, 8'h03, 3'd6, 1'b0},
      {8'hFF, 8'h02, 3'd7, 1'b0},
      {8'hFF, 8'h1C, 3'd3, 1'b0},
      {8'hFF, 8'h18, 3'd4, 1'b0},
      {8'hFF, 8'h3F, 3'd1, 1'b0},
      {8'hFF, 8'h40, 3'd2, 1'b0},
      {8'hFF, 8'h80, 3'd0, 1'b0},
      {8'h00, 8'hFF, 3'd0, 1'b1},
      {8'hDF, 8'hFF, 3'd2, 1'b0},
      {8'h9F, 8'h7F, 3'd3, 1'b0},
      {8'h03, 8'h1C, 3'd0, 1'b1}
   };

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic host(input logic [1:0] sel, input logic [7:0] mask, input logic [7:0] data);
      wr_en_i = 1'b1; wr_sel_i = sel; wr_mask_i = mask; wr_data_i = data;
      @(negedge clk);
      wr_en_i = 1'b0; wr_mask_i = '0; wr_data_i = '0;
   endtask

   task automatic rd(input logic [1:0] sel, output logic [7:0] v);
      rd_sel_i = sel;
      #0.5;
      v = rd_data_o;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual hung expected done");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic [7:0] v;
      repeat (3) @(negedge clk);
      // R1 reset state
      check("R1 int_n", int_n_o, 1);
      check("R1 icod", icod_o, 0);
      rd(2'd0, v); check("R1 flags", v, 0);
      rd(2'd1, v); check("R1 enables", v, 0);
      rd(2'd2, v); check("R1 ovf", v, 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 R5 R9 R2: table walk
      foreach (VEC[k]) begin
         host(2'd1, 8'hFF, VEC[k][19:12]);
         host(2'd0, 8'hFF, VEC[k][11:4]);
         check("R7 code", icod_o, VEC[k][3:1]);
         check("R5 int_n", int_n_o, VEC[k][0]);
         rd(2'd0, v); check("R2 flag readback", v, VEC[k][11:4]);
         rd(2'd1, v); check("R2 enable readback", v, VEC[k][19:12]);
      end

      // R3 hardware pulse lowers int on the following cycle
      host(2'd0, 8'hFF, 8'h00);
      host(2'd1, 8'hFF, 8'h08);
      hw_set_i = 8'h08;
      #0.5 check("R3 int before edge", int_n_o, 1);
      @(negedge clk); hw_set_i = '0;
      check("R3 int after set", int_n_o, 0);
      check("R7 TX1 code", icod_o, 4);
      host(2'd1, 8'hFF, 8'h00);
      check("R3 int after disable", int_n_o, 1);

      // R4 hold blocks clear
      host(2'd0, 8'hFF, 8'h04);
      hold_i = 8'h04;
      host(2'd0, 8'h04, 8'h00);
      rd(2'd0, v); check("R4 held flag", v, 8'h04);
      hold_i = 8'h00;
      host(2'd0, 8'h04, 8'h00);
      rd(2'd0, v); check("R4 released clear", v, 8'h00);

      // R6 masked modify with concurrent hardware set
      host(2'd0, 8'hFF, 8'h0F);
      hw_set_i = 8'h10;
      host(2'd0, 8'h01, 8'h00);
      hw_set_i = '0;
      rd(2'd0, v); check("R6 modify keeps hw set", v, 8'h1E);
      hw_set_i = 8'h02;
      host(2'd0, 8'h02, 8'h00);
      hw_set_i = '0;
      rd(2'd0, v); check("R6 set wins", v, 8'h1E);

      // R8 code steps down as winners clear
      host(2'd1, 8'hFF, 8'hFF);
      host(2'd0, 8'hFF, 8'h28);
      hw_set_i = 8'h02; @(negedge clk); hw_set_i = '0;
      check("R8 start", icod_o, 1);
      host(2'd0, 8'h20, 8'h00); check("R8 after err", icod_o, 4);
      host(2'd0, 8'h08, 8'h00); check("R8 after tx1", icod_o, 7);
      host(2'd0, 8'h02, 8'h00); check("R8 after rx1", icod_o, 0);
      check("R8 int released", int_n_o, 1);

      // R10 R11 overflow
      host(2'd1, 8'hFF, 8'h00);
      rx_accept_i = 2'b01; @(negedge clk); rx_accept_i = '0;
      rd(2'd0, v); check("R10 rx0 filled", v, 8'h01);
      rd(2'd2, v); check("R10 no ovf yet", v, 8'h00);
      rx_accept_i = 2'b01; @(negedge clk); rx_accept_i = '0;
      rd(2'd2, v); check("R10 ovf set", v, 8'h01);
      rd(2'd0, v); check("R10 err raised", v, 8'h21);
      host(2'd0, 8'hFF, 8'h00);
      rd(2'd2, v); check("R11 ovf survives flag write", v, 8'h01);
      host(2'd2, 8'h01, 8'h00);
      rd(2'd2, v); check("R11 ovf cleared", v, 8'h00);

      // R12 wake
      sleep_i = 1'b1; bus_act_i = 1'b1; @(negedge clk); bus_act_i = 1'b0;
      check("R12 no wake without enable", wake_req_o, 0);
      rd(2'd0, v); check("R12 no flag without enable", v, 8'h00);
      host(2'd1, 8'hFF, 8'h40);
      bus_act_i = 1'b1; @(negedge clk); bus_act_i = 1'b0;
      check("R12 wake req", wake_req_o, 1);
      check("R12 wake code", icod_o, 2);
      @(negedge clk);
      check("R12 wake one cycle", wake_req_o, 0);
      host(2'd0, 8'hFF, 8'h00);
      sleep_i = 1'b0; bus_act_i = 1'b1; @(negedge clk); bus_act_i = 1'b0;
      check("R12 no wake when awake", wake_req_o, 0);
      rd(2'd0, v); check("R12 no flag when awake", v, 8'h00);

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule